// File: doc/BRIEF.md
# Transport-Stream PID Filter

This block sits on a byte-wide transport-stream path and decides, packet by packet, whether each 188-byte packet goes on downstream or is thrown away. The decision rests on the 13-bit packet identifier (PID) carried in the packet header. The block builds it from the second and third bytes of each packet and compares it against several kinds of rule at once. Six named fixed slots each match one PID: stream 1, stream 2, clock reference, program map, entitlement management and entitlement control. A group rule compares a masked PID against a programmed value. An indexed bank of 32 general entries each match one PID. A null-packet rule overrides all of these.

The packet start is marked by `in_sof` on the first byte. Every byte travels through a short delay line, so the verdict, which is only known once the third byte is in, can still pass or drop the packet's own header. The verdict is also reported on a separate decision strobe. A master receive enable silences the block completely when it is cleared.

Top module: `ts_pid_filter`

## Requirements
- R1: The PID of a packet is `{byte1[4:0], byte2}`, where byte 0 is the beat flagged by `in_sof` and bytes 1 and 2 are the next two valid beats. `byte1[7:5]` has no influence on the verdict.
- R2: Fixed slot i (0 stream 1, 1 stream 2, 2 clock reference, 3 program map, 4 entitlement management, 5 entitlement control) compares against `slot_pid[13*i +: 13]`. It contributes a hit only when `slot_en[i]` is 1.
- R3: The group rule hits when `grp_en` is 1 and `(pid & grp_mask) == grp_pid`. When `grp_en` is 0 it never hits.
- R4: A cycle with `tbl_we` high writes `tbl_pid` and `tbl_on` into general entry `tbl_idx` (0 to 31), replacing what was there. An entry hits only when its enable is 1. After reset all 32 entries are disabled.
- R5: When `null_en` is 1, a packet with PID 0x1FFF is dropped even if another rule hits. When `null_en` is 0, such a packet is treated like any other PID.
- R6: One cycle after the beat carrying byte 2, `dec_valid` pulses once and `dec_pass` shows 1 if any enabled rule hit (subject to R5), else 0. The configuration used is the one present on that byte-2 beat.
- R7: While `rcv_en` is 0, no decision is made and no byte is emitted: `dec_valid` and `out_valid` are 0 in the following cycle. A packet whose byte 2 arrives with `rcv_en` at 0 is dropped whole.
- R8: Each input byte leaves, with its `in_sof` flag, on the cycle after the third later valid input beat. It leaves only if its packet passed and `rcv_en` is 1 on that beat. Bytes received before the first start marker are dropped.
- R9: After reset, `dec_valid` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rcv_en | input | 1 | Master receive enable |
| slot_en | input | 6 | Per-slot enable for the fixed slots |
| slot_pid | input | 78 | Fixed slot PIDs, slot i at bits 13*i+12..13*i |
| null_en | input | 1 | Null-packet drop rule enable |
| grp_en | input | 1 | Group rule enable |
| grp_pid | input | 13 | Group rule compare value |
| grp_mask | input | 13 | Group rule AND mask |
| tbl_we | input | 1 | General entry write strobe |
| tbl_idx | input | 5 | General entry index |
| tbl_pid | input | 13 | PID written to the entry |
| tbl_on | input | 1 | Enable written to the entry |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first of a packet |
| in_data | input | 8 | Input byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_pass | output | 1 | Packet verdict, 1 means pass |
| out_valid | output | 1 | Filtered byte valid |
| out_sof | output | 1 | Filtered byte is the first of a packet |
| out_data | output | 8 | Filtered byte |

## Verification
A packet's verdict and the emission of the previous packet's last three bytes fall on the same beats. While bytes 0 to 2 of packet N+1 arrive, bytes 185 to 187 of packet N still leave, gated by N's verdict and not N+1's. The bench provokes this by sending packets back to back with opposite verdicts, sometimes with idle gaps inside them. A reference model tracks every byte with its packet number and judges each emitted byte against that packet's own expected verdict. The same overlap is driven across a change of `rcv_en`, where the tail of a passing packet must vanish.

// File: rtl/ts_pidf_pkg.sv
package ts_pidf_pkg;

   localparam int TS_BYTE_W   = 8;
   localparam int TS_PID_W    = 13;
   localparam int TS_PID_HI_W = TS_PID_W - TS_BYTE_W;

   typedef logic [TS_PID_W-1:0]  pid_t;
   typedef logic [TS_BYTE_W-1:0] tbyte_t;

   localparam pid_t TS_NULL_PID = '1;

   // one beat held in the delay line
   typedef struct packed {
      logic   vld;
      logic   sof;
      tbyte_t data;
   } beat_t;

endpackage

// File: rtl/ts_pid_extract.sv
// Tracks the byte position inside the current packet and assembles the PID.
module ts_pid_extract
   import ts_pidf_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   in_valid,
   input  logic   in_sof,
   input  tbyte_t in_data,
   output logic   pid_strobe,
   output pid_t   pid
);

   localparam logic [1:0] POS_B1   = 2'd1;
   localparam logic [1:0] POS_B2   = 2'd2;
   localparam logic [1:0] POS_IDLE = 2'd3;

   logic [1:0]             pos_q;
   logic [TS_PID_HI_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= POS_IDLE;
         hi_q  <= '0;
      end else if (in_valid) begin
         if (in_sof)
            pos_q <= POS_B1;
         else if (pos_q != POS_IDLE)
            pos_q <= pos_q + 2'd1;
         if (!in_sof && pos_q == POS_B1)
            hi_q <= in_data[TS_PID_HI_W-1:0];
      end
   end

   assign pid_strobe = in_valid && !in_sof && (pos_q == POS_B2);
   assign pid        = {hi_q, in_data};

endmodule

// File: rtl/ts_pid_rules.sv
// Fixed slots, group rule and null rule, all combinational on the PID.
module ts_pid_rules
   import ts_pidf_pkg::*;
#(
   parameter int NUM_SLOTS = 6,
   parameter bit HAS_GROUP = 1'b1
)(
   input  pid_t                        pid,
   input  logic [NUM_SLOTS-1:0]        slot_en,
   input  logic [NUM_SLOTS*TS_PID_W-1:0] slot_pid,
   input  logic                        null_en,
   input  logic                        grp_en,
   input  pid_t                        grp_pid,
   input  pid_t                        grp_mask,
   output logic                        any_hit,
   output logic                        null_veto
);

   logic [NUM_SLOTS-1:0] slot_hit;
   logic                 grp_hit;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      assign slot_hit[i] = slot_en[i] &&
                           (pid == slot_pid[i*TS_PID_W +: TS_PID_W]);
   end

   if (HAS_GROUP) begin : g_grp
      assign grp_hit = grp_en && ((pid & grp_mask) == grp_pid);
   end else begin : g_nogrp
      logic unused_grp;
      assign unused_grp = ^{grp_en, grp_pid, grp_mask};
      assign grp_hit    = 1'b0;
   end

   assign any_hit   = (|slot_hit) || grp_hit;
   assign null_veto = null_en && (pid == TS_NULL_PID);

endmodule

// File: rtl/ts_pid_table.sv
// Indexed bank of general PID entries with parallel match.
module ts_pid_table
   import ts_pidf_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int IDX_W = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  pid_t             wr_pid,
   input  logic             wr_on,
   input  pid_t             pid,
   output logic             hit
);

   logic [DEPTH-1:0] ent_hit;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      pid_t ent_pid;
      logic ent_on;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_pid <= '0;
            ent_on  <= 1'b0;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            ent_pid <= wr_pid;
            ent_on  <= wr_on;
         end
      end

      assign ent_hit[i] = ent_on && (ent_pid == pid);
   end

   assign hit = |ent_hit;

endmodule

// File: rtl/ts_byte_delay.sv
// Fixed-length shift line of beats, advanced only on valid input.
module ts_byte_delay
   import ts_pidf_pkg::*;
#(
   parameter int DLY = 3
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  push,
   input  beat_t din,
   output beat_t tail
);

   for (genvar k = 0; k < DLY; k++) begin : g_stg
      beat_t q;
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= '0;
            else if (push) q <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= '0;
            else if (push) q <= g_stg[k-1].q;
         end
      end
   end

   assign tail = g_stg[DLY-1].q;

endmodule

// File: rtl/ts_pid_filter.sv
// Transport-stream PID filter top.
module ts_pid_filter
   import ts_pidf_pkg::*;
#(
   parameter int NUM_SLOTS = 6,
   parameter int TBL_DEPTH = 32,
   parameter int DLY       = 3,
   parameter bit HAS_GROUP = 1'b1,
   localparam int IDX_W    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1,
   localparam int SLOT_BW  = NUM_SLOTS * TS_PID_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rcv_en,
   input  logic [NUM_SLOTS-1:0] slot_en,
   input  logic [SLOT_BW-1:0] slot_pid,
   input  logic               null_en,
   input  logic               grp_en,
   input  logic [TS_PID_W-1:0] grp_pid,
   input  logic [TS_PID_W-1:0] grp_mask,
   input  logic               tbl_we,
   input  logic [IDX_W-1:0]   tbl_idx,
   input  logic [TS_PID_W-1:0] tbl_pid,
   input  logic               tbl_on,
   input  logic               in_valid,
   input  logic               in_sof,
   input  logic [TS_BYTE_W-1:0] in_data,
   output logic               dec_valid,
   output logic               dec_pass,
   output logic               out_valid,
   output logic               out_sof,
   output logic [TS_BYTE_W-1:0] out_data
);

   // elaboration-time parameter checks
   if (DLY < 3) begin : g_chk_dly
      $error("ts_pid_filter: DLY must cover the three header bytes");
   end
   if (NUM_SLOTS < 1) begin : g_chk_slots
      $error("ts_pid_filter: NUM_SLOTS must be at least 1");
   end
   if (TBL_DEPTH < 1 || TBL_DEPTH > (1 << IDX_W)) begin : g_chk_tbl
      $error("ts_pid_filter: TBL_DEPTH out of range");
   end

   logic  pid_strobe;
   pid_t  cur_pid;
   logic  rule_hit;
   logic  null_veto;
   logic  tbl_hit;
   logic  verdict;
   logic  pend_q;
   logic  dec_q;
   logic  gate_q;
   logic  gate_now;
   beat_t din_beat;
   beat_t tail_beat;

   ts_pid_extract u_extract (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sof     (in_sof),
      .in_data    (in_data),
      .pid_strobe (pid_strobe),
      .pid        (cur_pid)
   );

   ts_pid_rules #(
      .NUM_SLOTS (NUM_SLOTS),
      .HAS_GROUP (HAS_GROUP)
   ) u_rules (
      .pid       (cur_pid),
      .slot_en   (slot_en),
      .slot_pid  (slot_pid),
      .null_en   (null_en),
      .grp_en    (grp_en),
      .grp_pid   (grp_pid),
      .grp_mask  (grp_mask),
      .any_hit   (rule_hit),
      .null_veto (null_veto)
   );

   ts_pid_table #(
      .DEPTH (TBL_DEPTH),
      .IDX_W (IDX_W)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tbl_we),
      .wr_idx (tbl_idx),
      .wr_pid (tbl_pid),
      .wr_on  (tbl_on),
      .pid    (cur_pid),
      .hit    (tbl_hit)
   );

   assign verdict = rcv_en && (rule_hit || tbl_hit) && !null_veto;

   // verdict of the packet now entering; cleared by each start marker
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         dec_q  <= 1'b0;
      end else begin
         dec_q <= pid_strobe && rcv_en;
         if (in_valid) begin
            if (in_sof)          pend_q <= 1'b0;
            else if (pid_strobe) pend_q <= verdict;
         end
      end
   end

   assign dec_valid = dec_q;
   assign dec_pass  = pend_q;

   assign din_beat = '{vld: 1'b1, sof: in_sof, data: in_data};

   ts_byte_delay #(
      .DLY (DLY)
   ) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid),
      .din   (din_beat),
      .tail  (tail_beat)
   );

   // the verdict of a packet is latched when its first byte leaves the line
   assign gate_now = tail_beat.sof ? pend_q : gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q    <= 1'b0;
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_data  <= '0;
      end else begin
         if (in_valid && tail_beat.vld)
            gate_q <= gate_now;
         out_valid <= in_valid && tail_beat.vld && gate_now && rcv_en;
         out_sof   <= in_valid && tail_beat.vld && gate_now && rcv_en && tail_beat.sof;
         out_data  <= tail_beat.data;
      end
   end

endmodule

// File: rtl/ts_pid_filter_chk.sv
// Property checker bound to the filter top.
module ts_pid_filter_chk
   import ts_pidf_pkg::*;
#(
   parameter int NUM_SLOTS = 6
)(
   input logic                          clk,
   input logic                          rst_n,
   input logic                          rcv_en,
   input logic [NUM_SLOTS-1:0]          slot_en,
   input logic [NUM_SLOTS*TS_PID_W-1:0] slot_pid,
   input logic                          null_en,
   input logic                          in_valid,
   input logic                          in_sof,
   input logic [TS_BYTE_W-1:0]          in_data,
   input logic                          dec_valid,
   input logic                          dec_pass,
   input logic                          out_valid
);

   logic [1:0]                   c_pos;
   logic [TS_PID_HI_W-1:0]       c_hi;
   pid_t                         c_pid;
   logic                         q_rcv;
   logic                         q_null;
   logic [NUM_SLOTS-1:0]         q_en;
   logic [NUM_SLOTS*TS_PID_W-1:0] q_pid;
   logic                         slot_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_pos  <= 2'd3;
         c_hi   <= '0;
         c_pid  <= '0;
         q_rcv  <= 1'b0;
         q_null <= 1'b0;
         q_en   <= '0;
         q_pid  <= '0;
      end else begin
         q_rcv  <= rcv_en;
         q_null <= null_en;
         q_en   <= slot_en;
         q_pid  <= slot_pid;
         if (in_valid) begin
            if (in_sof)               c_pos <= 2'd1;
            else if (c_pos != 2'd3)   c_pos <= c_pos + 2'd1;
            if (!in_sof && c_pos == 2'd1) c_hi  <= in_data[TS_PID_HI_W-1:0];
            if (!in_sof && c_pos == 2'd2) c_pid <= {c_hi, in_data};
         end
      end
   end

   always_comb begin
      slot_any = 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++)
         if (q_en[i] && q_pid[i*TS_PID_W +: TS_PID_W] == c_pid)
            slot_any = 1'b1;
   end

   // R7: a cleared master enable silences both outputs
   a_r7_rcv_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rcv_en |=> (!out_valid && !dec_valid));

   // R5: null override
   a_r5_null_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && q_null && c_pid == TS_NULL_PID) |-> !dec_pass);

   // R2: an enabled slot hit passes the packet
   a_r2_slot_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && q_rcv && slot_any && !(q_null && c_pid == TS_NULL_PID)) |-> dec_pass);

   // R6: a decision never repeats on consecutive cycles
   a_r6_single_decision: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   // R6: a decision follows a non-start input beat
   a_r6_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> ($past(in_valid) && !$past(in_sof)));

   // R8: an output byte follows an input beat under an active enable
   a_r8_output_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(in_valid) && $past(rcv_en)));

endmodule

bind ts_pid_filter ts_pid_filter_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rcv_en    (rcv_en),
   .slot_en   (slot_en),
   .slot_pid  (slot_pid),
   .null_en   (null_en),
   .in_valid  (in_valid),
   .in_sof    (in_sof),
   .in_data   (in_data),
   .dec_valid (dec_valid),
   .dec_pass  (dec_pass),
   .out_valid (out_valid)
);

// File: tb/tb_ts_pid_filter.sv
`timescale 1ns/1ps
module tb_ts_pid_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rcv_en = 1'b0;
   logic [5:0]  slot_en = '0;
   logic [77:0] slot_pid = '0;
   logic        null_en = 1'b0;
   logic        grp_en = 1'b0;
   logic [12:0] grp_pid = '0;
   logic [12:0] grp_mask = '0;
   logic        tbl_we = 1'b0;
   logic [4:0]  tbl_idx = '0;
   logic [12:0] tbl_pid = '0;
   logic        tbl_on = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sof = 1'b0;
   logic [7:0]  in_data = '0;
   logic        dec_valid, dec_pass, out_valid, out_sof;
   logic [7:0]  out_data;

   always #2.5 clk = ~clk;

   ts_pid_filter dut (.*);

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int out_seen = 0;
   int dec_seen = 0;

   bit [12:0]   m_tbl_pid [32];
   bit          m_tbl_on  [32];
   logic [8:0]  exp_out [$];
   bit          exp_dec [$];
   string       exp_tag [$];
   logic [7:0]  h_data [$];
   bit          h_sof  [$];
   int          h_pkt  [$];
   bit          pkt_pass [int];
   int          pkt_id = -1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit model_pass(input logic [12:0] p);
      bit hit = 1'b0;
      for (int i = 0; i < 6; i++)
         if (slot_en[i] && slot_pid[i*13 +: 13] == p) hit = 1'b1;
      if (grp_en && ((p & grp_mask) == grp_pid)) hit = 1'b1;
      for (int i = 0; i < 32; i++)
         if (m_tbl_on[i] && m_tbl_pid[i] == p) hit = 1'b1;
      if (null_en && p == 13'h1FFF) hit = 1'b0;
      return hit;
   endfunction

   // output and decision monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            out_seen++;
            if (exp_out.size() == 0)
               check(1'b0, "R8 unexpected byte", {out_sof, out_data}, 0);
            else begin
               logic [8:0] e;
               e = exp_out.pop_front();
               check({out_sof, out_data} === e, "R8 byte stream", {out_sof, out_data}, e);
            end
         end
         if (dec_valid) begin
            dec_seen++;
            if (exp_dec.size() == 0)
               check(1'b0, "R6 unexpected decision", dec_pass, 0);
            else begin
               bit    e;
               string t;
               e = exp_dec.pop_front();
               t = exp_tag.pop_front();
               check(dec_pass === e, {"R6 verdict ", t}, dec_pass, e);
            end
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sof   = 1'b0;
      end
   endtask

   task automatic beat(input bit sof, input logic [7:0] d, input int pkt,
                       input string tag, input int bidx, input logic [12:0] pid);
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = sof;
      in_data  = d;
      if (bidx == 2) begin
         bit p;
         p = rcv_en && model_pass(pid);
         pkt_pass[pkt] = p;
         if (rcv_en) begin
            exp_dec.push_back(p);
            exp_tag.push_back(tag);
         end
      end
      h_data.push_back(d);
      h_sof.push_back(sof);
      h_pkt.push_back(pkt);
      if (h_data.size() > 3) begin
         logic [7:0] d0;
         bit         s0;
         int         k0;
         d0 = h_data.pop_front();
         s0 = h_sof.pop_front();
         k0 = h_pkt.pop_front();
         if (pkt_pass.exists(k0) && pkt_pass[k0] && rcv_en)
            exp_out.push_back({s0, d0});
      end
   endtask

   task automatic send_pkt(input logic [12:0] pid, input string tag,
                           input int len, input int gapmax);
      pkt_id++;
      for (int b = 0; b < len; b++) begin
         logic [7:0] d;
         if (b == 0)      d = 8'h47;
         else if (b == 1) d = {3'($urandom), pid[12:8]};
         else if (b == 2) d = pid[7:0];
         else             d = 8'($urandom);
         beat(b == 0, d, pkt_id, tag, b, pid);
         if (gapmax > 0 && $urandom_range(0, 3) == 0)
            idle($urandom_range(1, gapmax));
      end
      idle(1);
   endtask

   task automatic tbl_write(input int idx, input logic [12:0] p, input bit on);
      @(negedge clk);
      in_valid = 1'b0;
      tbl_we   = 1'b1;
      tbl_idx  = 5'(idx);
      tbl_pid  = p;
      tbl_on   = on;
      @(negedge clk);
      tbl_we   = 1'b0;
      m_tbl_pid[idx] = p;
      m_tbl_on[idx]  = on;
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int o0, d0;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 32; i++) begin
         m_tbl_pid[i] = '0;
         m_tbl_on[i]  = 1'b0;
      end
      pkt_pass[-1] = 1'b0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check(dec_valid === 1'b0, "R9 dec_valid after reset", dec_valid, 0);
      check(out_valid === 1'b0, "R9 out_valid after reset", out_valid, 0);
      rcv_en = 1'b1;

      // R8: bytes before any start marker are dropped
      for (int j = 0; j < 5; j++) beat(1'b0, 8'(j + 1), -1, "R8", 9, 13'h0);
      idle(1);

      // R4: table entries start disabled (their stored PID is 0)
      send_pkt(13'h0000, "R4 reset", 188, 0);

      // R2 fixed slots
      idle(1);
      slot_pid[0*13 +: 13] = 13'h0100;
      slot_pid[1*13 +: 13] = 13'h0200;
      slot_pid[2*13 +: 13] = 13'h0300;
      slot_pid[3*13 +: 13] = 13'h0010;
      slot_pid[4*13 +: 13] = 13'h1ABC;
      slot_pid[5*13 +: 13] = 13'h0020;
      slot_en = 6'b111101;
      send_pkt(13'h0100, "R2 stream1", 188, 0);
      send_pkt(13'h0200, "R2 disabled slot", 188, 0);
      send_pkt(13'h0300, "R2 pcr", 188, 2);
      send_pkt(13'h0020, "R2 ecm", 188, 0);
      send_pkt(13'h1ABC, "R1 high pid bits", 188, 0);
      send_pkt(13'h1ABD, "R1 near miss", 188, 0);

      // R3 group rule
      idle(1);
      grp_pid = 13'h0400; grp_mask = 13'h1F00; grp_en = 1'b1;
      send_pkt(13'h04AB, "R3 masked hit", 188, 0);
      send_pkt(13'h05AB, "R3 masked miss", 188, 0);
      idle(1);
      grp_en = 1'b0;
      send_pkt(13'h04AB, "R3 disabled", 188, 0);

      // R4 general entries
      tbl_write(0, 13'h0777, 1'b1);
      tbl_write(31, 13'h0888, 1'b1);
      tbl_write(5, 13'h0999, 1'b0);
      send_pkt(13'h0777, "R4 index 0", 188, 0);
      send_pkt(13'h0888, "R4 index 31", 188, 0);
      send_pkt(13'h0999, "R4 entry off", 188, 0);
      tbl_write(0, 13'h0778, 1'b1);
      send_pkt(13'h0777, "R4 overwritten", 188, 0);
      send_pkt(13'h0778, "R4 new value", 188, 0);

      // R5 null rule
      idle(1);
      slot_pid[0*13 +: 13] = 13'h1FFF;
      null_en = 1'b0;
      send_pkt(13'h1FFF, "R5 null rule off", 188, 0);
      idle(1);
      null_en = 1'b1;
      send_pkt(13'h1FFF, "R5 null override", 188, 0);
      null_en = 1'b0;
      slot_pid[0*13 +: 13] = 13'h0100;

      // R7 master enable off, also cutting the previous packet's tail
      send_pkt(13'h0100, "R7 before off", 188, 0);
      idle(1);
      rcv_en = 1'b0;
      o0 = out_seen; d0 = dec_seen;
      send_pkt(13'h0100, "R7", 188, 0);
      send_pkt(13'h0778, "R7", 188, 1);
      idle(2);
      check(out_seen == o0, "R7 no output while disabled", out_seen - o0, 0);
      check(dec_seen == d0, "R7 no decision while disabled", dec_seen - d0, 0);
      rcv_en = 1'b1;
      send_pkt(13'h0300, "R7 after on", 188, 0);

      // random mix with back-to-back packets of opposite verdicts
      for (int n = 0; n < 40; n++) begin
         logic [12:0] p;
         int          r;
         idle(1);
         slot_en = 6'($urandom);
         null_en = 1'($urandom);
         grp_en  = 1'($urandom);
         r = $urandom_range(0, 5);
         case (r)
            0: p = slot_pid[$urandom_range(0, 5)*13 +: 13];
            1: p = 13'h0400 | 13'($urandom_range(0, 255));
            2: p = ($urandom_range(0, 1) == 0) ? 13'h0778 : 13'h0888;
            3: p = 13'h1FFF;
            default: p = 13'($urandom);
         endcase
         send_pkt(p, "R6 random", 188, (n % 3 == 0) ? 2 : 0);
      end

      // flush the final tail with a header-only packet
      send_pkt(13'h0100, "R6 flush", 3, 0);
      idle(6);
      check(exp_out.size() == 0, "R8 all expected bytes emitted", exp_out.size(), 0);
      check(exp_dec.size() == 0, "R6 all decisions seen", exp_dec.size(), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule